// File: doc/BRIEF.md
# FM Single-Density Disc Write Serializer

This block turns a stream of byte pairs into the pulse train written to a single-density (FM) floppy track. A byte-level controller talks to it through an eight-slot register window. For every byte period the engine takes one clock byte and one data byte and sends them out as eight bit cells. Each cell is a clock half followed by a data half, most significant bit first. Because the clock byte is loaded separately from the data byte, the controller can leave clock pulses out on purpose. This is how address marks such as data 0xFE with clocks 0xC7 are written.

At the start of every byte it takes from the host registers, the engine raises a one-cycle request. The controller then has the rest of that byte period to load the next pair. If it loads nothing, the engine sends the same pair again. A CRC-16 can be gathered over the data bytes. On request, the engine appends the CRC as two further bytes with full clocks, then clears the request and presets the CRC for the next field. A read-direction bit and an idle bit both stop the write stream.

Top module: `fm_bit_engine`

## Requirements
- R1: After reset, the control slot reads 0x08 (idle), `pulse_out`, `byte_req` and `drive_out` are low, and the status slot reads 0x00.
- R2: Slot addresses are 0 control (low 4 bits), 1 status, 2 drive input, 3 drive output, 4 clock byte, 5 data byte, 6 data input and 7 spare. Slot 2 reads the `drive_in` pins. A write to slot 3 appears on `drive_out` and is the only thing that changes it. Slot 6 reads 0x00 and slot 7 reads 0xFF.
- R3: Each byte is 16 half cells of `HALF_CYC` cycles, in the order clock bit 7, data bit 7, clock bit 6, and so on down to data bit 0. A 1 gives a pulse on `pulse_out` from the first cycle of its half cell that lasts exactly `PULSE_CYC` cycles. A 0 gives no pulse.
- R4: Clock bits are sent exactly as loaded, so a pair of data 0xFE and clocks 0xC7 comes out with its clock pulses missing.
- R5: The host pair is taken at each byte boundary, and `byte_req` is high for exactly one cycle at the start of that byte. A pair written during a byte period goes out in the next byte.
- R6: If no new pair is written during a byte period, the previous host pair is sent again.
- R7: When control bit 0 is set, each host data byte updates a CRC-16 (polynomial 0x1021, MSB first, preset 0xFFFF) at the moment it is taken. Clock bytes are never included, and neither are data bytes taken while bit 0 is clear.
- R8: When control bit 1 is set at a byte boundary, the next two bytes are the CRC high byte and then the CRC low byte, both with clocks 0xFF, and no `byte_req` is raised for them. Bit 1 then clears by itself and the CRC returns to 0xFFFF.
- R9: Status bit 0 is 1 while the write stream runs. Status bit 1 is 1 while a CRC byte is being sent. All other status bits are 0.
- R10: While control bit 2 (read) or bit 3 (idle) is set, `pulse_out` and `byte_req` stay low. When both bits are clear, the stream starts on the next clock edge with the current host pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one engine cycle |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register window write strobe |
| reg_addr | input | 3 | Register window slot |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed slot (combinational) |
| drive_in | input | 8 | Drive status lines |
| drive_out | output | 8 | Drive control lines |
| pulse_out | output | 1 | FM write pulse stream |
| byte_req | output | 1 | One-cycle request for the next byte pair |

## Verification
If the half-cell counter or shifter slips, every later bit cell moves, so the decoded clock and data bytes at `pulse_out` are wrong from the first damaged byte onward. A wrong CRC register shows up only in the two appended bytes. That can happen long after the fault, so the bench ends each field with a finish and compares both CRC bytes against its own computation. A fault in the append sequencer shows up at once: a stray or missing `byte_req`, a finish bit that never clears, or a gap between requests that is too short.

// File: rtl/fm_eng_pkg.sv
package fm_eng_pkg;

    typedef enum logic [2:0] {
        SL_CTRL  = 3'd0,
        SL_STAT  = 3'd1,
        SL_DIN   = 3'd2,
        SL_DOUT  = 3'd3,
        SL_CLKB  = 3'd4,
        SL_DATB  = 3'd5,
        SL_RDB   = 3'd6,
        SL_SPARE = 3'd7
    } slot_e;

    localparam int C_GATHER = 0;
    localparam int C_FINISH = 1;
    localparam int C_READ   = 2;
    localparam int C_IDLE   = 3;

    localparam logic [3:0]  CTRL_RESET = 4'b1000;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;

    typedef struct packed {
        logic [7:0] clk_b;
        logic [7:0] dat_b;
    } pair_t;

    // which byte the shifter currently holds
    typedef enum logic [1:0] {AP_NONE, AP_HI, AP_LO} app_e;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    // clock bit above data bit, cell 7 at the top
    function automatic logic [15:0] weave(input pair_t p);
        logic [15:0] w;
        for (int i = 0; i < 8; i++) begin
            w[2*i+1] = p.clk_b[i];
            w[2*i]   = p.dat_b[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/fm_reg_window.sv
module fm_reg_window
    import fm_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    input  logic [7:0] drive_in,
    input  logic [1:0] status,
    input  logic       fin_done,
    output logic [3:0] ctrl,
    output logic [7:0] drive_out,
    output pair_t      host,
    output logic [7:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= CTRL_RESET;
            drive_out  <= 8'h00;
            host.clk_b <= 8'hFF;
            host.dat_b <= 8'h00;
        end else begin
            if (fin_done) ctrl[C_FINISH] <= 1'b0;
            if (we) begin
                case (slot_e'(addr))
                    SL_CTRL: ctrl       <= wdata[3:0];
                    SL_DOUT: drive_out  <= wdata;
                    SL_CLKB: host.clk_b <= wdata;
                    SL_DATB: host.dat_b <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (slot_e'(addr))
            SL_CTRL:  rdata = {4'h0, ctrl};
            SL_STAT:  rdata = {6'h00, status};
            SL_DIN:   rdata = drive_in;
            SL_DOUT:  rdata = drive_out;
            SL_CLKB:  rdata = host.clk_b;
            SL_DATB:  rdata = host.dat_b;
            SL_RDB:   rdata = 8'h00;
            default:  rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/fm_crc16.sv
module fm_crc16
    import fm_eng_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        gather,
    input  logic [7:0]  din,
    input  logic        preset,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || preset) crc <= CRC_INIT;
        else if (gather)   crc <= crc_step(crc, din);
    end
endmodule

// File: rtl/fm_cell_shifter.sv
module fm_cell_shifter
    import fm_eng_pkg::*;
#(
    parameter int HALF_CYC  = 8,
    parameter int PULSE_CYC = 2
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        active,
    input  logic        fin_req,
    input  pair_t       host,
    input  logic [15:0] crc,
    output logic        pulse_out,
    output logic        byte_req,
    output logic        host_load,
    output logic        fin_done,
    output logic        streaming,
    output logic        appending
);
    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST_CYC = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] PW       = CW'(PULSE_CYC);

    logic          run;
    logic [CW-1:0] cyc;
    logic [3:0]    half;
    logic [15:0]   shreg;
    logic [7:0]    crc_lo_q;
    app_e          app_st;

    logic        end_half, end_byte, load, start_app;
    logic [15:0] next_word;

    assign end_half  = (cyc == LAST_CYC);
    assign end_byte  = end_half && (half == 4'd15);
    assign load      = active && (!run || end_byte);
    assign fin_done  = load && (app_st == AP_HI);
    assign start_app = load && (app_st != AP_HI) && fin_req;
    assign host_load = load && !fin_done && !start_app;

    always_comb begin
        if (app_st == AP_HI)  next_word = weave('{clk_b: 8'hFF, dat_b: crc_lo_q});
        else if (fin_req)     next_word = weave('{clk_b: 8'hFF, dat_b: crc[15:8]});
        else                  next_word = weave(host);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            cyc      <= '0;
            half     <= 4'd0;
            shreg    <= 16'h0000;
            crc_lo_q <= 8'h00;
            app_st   <= AP_NONE;
            byte_req <= 1'b0;
        end else begin
            byte_req <= 1'b0;
            if (!active) begin
                run    <= 1'b0;
                cyc    <= '0;
                half   <= 4'd0;
                app_st <= AP_NONE;
            end else if (load) begin
                run      <= 1'b1;
                cyc      <= '0;
                half     <= 4'd0;
                shreg    <= next_word;
                byte_req <= host_load;
                if (start_app) begin
                    crc_lo_q <= crc[7:0];
                    app_st   <= AP_HI;
                end else if (fin_done) begin
                    app_st   <= AP_LO;
                end else begin
                    app_st   <= AP_NONE;
                end
            end else if (end_half) begin
                cyc   <= '0;
                half  <= half + 4'd1;
                shreg <= {shreg[14:0], 1'b0};
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    assign pulse_out = run && active && shreg[15] && (cyc < PW);
    assign streaming = run && active;
    assign appending = (app_st != AP_NONE);
endmodule

// File: rtl/fm_bit_engine.sv
module fm_bit_engine
    import fm_eng_pkg::*;
#(
    parameter int HALF_CYC  = 8,
    parameter int PULSE_CYC = 2
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [7:0] drive_in,
    output logic [7:0] drive_out,
    output logic       pulse_out,
    output logic       byte_req
);
    logic [3:0]  ctrl_q;
    pair_t       host;
    logic [15:0] crc;
    logic        host_load, fin_done, streaming, appending, active;

    assign active = !ctrl_q[C_IDLE] && !ctrl_q[C_READ];

    fm_reg_window u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .drive_in (drive_in),
        .status   ({appending, streaming}),
        .fin_done (fin_done),
        .ctrl     (ctrl_q),
        .drive_out(drive_out),
        .host     (host),
        .rdata    (reg_rdata)
    );

    fm_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .gather(host_load && ctrl_q[C_GATHER]),
        .din   (host.dat_b),
        .preset(fin_done),
        .crc   (crc)
    );

    fm_cell_shifter #(
        .HALF_CYC (HALF_CYC),
        .PULSE_CYC(PULSE_CYC)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .fin_req  (ctrl_q[C_FINISH]),
        .host     (host),
        .crc      (crc),
        .pulse_out(pulse_out),
        .byte_req (byte_req),
        .host_load(host_load),
        .fin_done (fin_done),
        .streaming(streaming),
        .appending(appending)
    );
endmodule

// File: rtl/fm_bit_engine_chk.sv
module fm_bit_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [7:0] drive_out,
    input logic       pulse_out,
    input logic       byte_req,
    input logic [1:0] stop_bits,
    input logic       appending
);
    assert_single_req_R5: assert property (@(posedge clk) disable iff (rst)
        byte_req |=> !byte_req);

    assert_no_req_in_crc_R8: assert property (@(posedge clk) disable iff (rst)
        byte_req |-> !appending);

    assert_quiet_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (stop_bits != 2'b00) |-> !pulse_out);

    assert_quiet_req_R10: assert property (@(posedge clk) disable iff (rst)
        (stop_bits != 2'b00) |=> !byte_req);

    assert_drive_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == 3'd3) |=> $stable(drive_out));
endmodule

bind fm_bit_engine fm_bit_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .drive_out(drive_out),
    .pulse_out(pulse_out),
    .byte_req (byte_req),
    .stop_bits(ctrl_q[3:2]),
    .appending(appending)
);

// File: tb/fm_bit_engine_tb.sv
module fm_bit_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int PW   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] drive_in = 8'h00;
    logic [7:0] drive_out;
    logic       pulse_out;
    logic       byte_req;

    int  checks = 0;
    int  failures = 0;
    int  cyc_now = 0;
    bit  finished = 0;
    bit  mon_arm = 0;
    bit  mon_busy = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_now <= cyc_now + 1;

    fm_bit_engine #(.HALF_CYC(HALF), .PULSE_CYC(PW)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drive_in(drive_in),
        .drive_out(drive_out), .pulse_out(pulse_out), .byte_req(byte_req)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_req();
        do @(negedge clk); while (!byte_req);
    endtask

    task automatic push(input logic [7:0] c, input logic [7:0] d, input string tag);
        exp_q.push_back({c, d});
        tag_q.push_back(tag);
    endtask

    task automatic wait_mon();
        while (mon_busy || exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: decodes the pulse stream byte by byte and compares
    initial begin
        logic [7:0]  gc, gd;
        logic [15:0] e;
        string       t;
        bit          werr;
        forever begin
            wait (mon_arm);
            do @(negedge clk); while (!byte_req);
            mon_arm  = 0;
            mon_busy = 1;
            while (exp_q.size() > 0) begin
                werr = 0;
                for (int h = 0; h < 16; h++) begin
                    if (h % 2 == 0) gc = {gc[6:0], pulse_out};
                    else            gd = {gd[6:0], pulse_out};
                    repeat (PW) @(negedge clk);
                    if (pulse_out) werr = 1;
                    repeat (HALF - PW) @(negedge clk);
                end
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({gc, gd} == e, t, "stream clk/data pair", {gc, gd}, e);
                chk(!werr, "R3", "pulse width", {31'd0, werr}, 0);
            end
            mon_busy = 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] crc1, crc2;
        int          t0, np, nr;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk(v == 8'h08, "R1", "ctrl after reset", v, 8'h08);
        rd(3'd1, v); chk(v == 8'h00, "R1", "status after reset", v, 8'h00);
        chk(!pulse_out && !byte_req, "R1", "outputs after reset", {pulse_out, byte_req}, 0);
        chk(drive_out == 8'h00, "R1", "drive_out after reset", drive_out, 0);

        // R2 register window
        wr(3'd3, 8'hA5);
        chk(drive_out == 8'hA5, "R2", "drive_out pins", drive_out, 8'hA5);
        rd(3'd3, v); chk(v == 8'hA5, "R2", "slot 3 readback", v, 8'hA5);
        drive_in = 8'h3C;
        rd(3'd2, v); chk(v == 8'h3C, "R2", "slot 2 drive_in", v, 8'h3C);
        rd(3'd7, v); chk(v == 8'hFF, "R2", "slot 7", v, 8'hFF);
        rd(3'd6, v); chk(v == 8'h00, "R2", "slot 6", v, 8'h00);
        wr(3'd1, 8'h55);
        chk(drive_out == 8'hA5, "R2", "drive_out after other write", drive_out, 8'hA5);

        // R10 read direction keeps the stream quiet
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        wr(3'd0, 8'h04);
        np = 0; nr = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (pulse_out) np++;
            if (byte_req)  nr++;
        end
        chk(np == 0 && nr == 0, "R10", "read mode activity", np + nr, 0);
        wr(3'd0, 8'h08);

        // Frame 1: plain bytes, address mark, repeat
        wr(3'd4, 8'hFF); wr(3'd5, 8'hE5); push(8'hFF, 8'hE5, "R3");
        mon_arm = 1;
        wr(3'd0, 8'h00);
        wait_req();
        rd(3'd1, v); chk(v == 8'h01, "R9", "status streaming", v, 8'h01);
        wr(3'd4, 8'hC7); wr(3'd5, 8'hFE); push(8'hC7, 8'hFE, "R4");
        wait_req();
        wr(3'd4, 8'hFF); wr(3'd5, 8'h5A); push(8'hFF, 8'h5A, "R5");
        wait_req();
        push(8'hFF, 8'h5A, "R6");
        wait_mon();
        wr(3'd0, 8'h08);
        repeat (2) @(negedge clk);
        np = 0; nr = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pulse_out) np++;
            if (byte_req)  nr++;
        end
        chk(np == 0 && nr == 0, "R10", "idle activity", np + nr, 0);
        rd(3'd1, v); chk(v == 8'h00, "R9", "status idle", v, 8'h00);

        // Frame 2: header field with CRC, then a second field
        crc1 = 16'hFFFF;
        wr(3'd4, 8'hC7); wr(3'd5, 8'hFE); push(8'hC7, 8'hFE, "R4");
        crc1 = ref_crc(crc1, 8'hFE);
        mon_arm = 1;
        wr(3'd0, 8'h01);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            b = (i == 2) ? 8'h01 : 8'h00;
            wait_req();
            wr(3'd4, 8'hFF); wr(3'd5, b); push(8'hFF, b, "R7");
            crc1 = ref_crc(crc1, b);
        end
        wait_req();
        wr(3'd0, 8'h02);
        t0 = cyc_now;
        push(8'hFF, crc1[15:8], "R8");
        push(8'hFF, crc1[7:0], "R7");
        push(8'hFF, 8'h00, "R6");
        repeat (70) @(negedge clk);
        rd(3'd1, v); chk(v == 8'h03, "R9", "status during CRC", v, 8'h03);
        wait_req();
        chk(cyc_now - t0 > 2 * 16 * HALF, "R8", "request gap over CRC", cyc_now - t0, 2 * 16 * HALF);
        rd(3'd0, v); chk(v == 8'h00, "R8", "finish bit cleared", v, 8'h00);
        wr(3'd4, 8'hC7); wr(3'd5, 8'hFB); wr(3'd0, 8'h01);
        push(8'hC7, 8'hFB, "R4");
        crc2 = ref_crc(16'hFFFF, 8'hFB);
        wait_req();
        wr(3'd4, 8'hFF); wr(3'd5, 8'h12); push(8'hFF, 8'h12, "R5");
        crc2 = ref_crc(crc2, 8'h12);
        wait_req();
        wr(3'd4, 8'hFF); wr(3'd5, 8'h34); push(8'hFF, 8'h34, "R5");
        crc2 = ref_crc(crc2, 8'h34);
        wait_req();
        wr(3'd0, 8'h03);
        push(8'hFF, crc2[15:8], "R8");
        push(8'hFF, crc2[7:0], "R8");
        push(8'hFF, 8'h34, "R6");
        wait_mon();
        wr(3'd0, 8'h08);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule